// File: doc/BRIEF.md
# Privileged Time-Slice Countdown Timer

This block is a supervisor timer. It makes sure that control returns to the operating system even when a user program loops forever or never gives up the processor. Only monitor-mode software can set it. Each load writes a start count. The count then drops by one on every cycle where the tick enable is high. When the count reaches zero, the block raises an interrupt so the supervisor can preempt the running program and switch time slices.

The block checks the privilege level of every load request. In monitor mode a load is accepted: the counter takes the new value and any pending interrupt is cleared. In user mode the request has no effect on the counter or the interrupt, and the block pulses a violation flag instead. A user program therefore cannot extend its own time slice or cancel the preemption.

After expiry the counter stays at zero and the interrupt stays high until the supervisor acknowledges it or loads a new value. Counting is stopped after reset and after a load of zero. It starts again only when a non-zero value is loaded.

Top module: `slice_timer`

## Requirements
- R1: After reset, `count` is 0, `irq` is 0 and `priv_viol` is 0, and the counter is stopped.
- R2: A load with `mode_user`=0 (monitor mode) puts `load_val` on `count` at the next clock edge and clears `irq` at that same edge.
- R3: A load with `mode_user`=1 (user mode) leaves `count` and `irq` unaffected by the load. It raises `priv_viol` for the one cycle after the request.
- R4: While the counter is running and not zero, `count` drops by exactly one on each cycle with `tick_en`=1 and holds on each cycle with `tick_en`=0.
- R5: The clock edge that takes `count` from 1 to 0 also sets `irq` to 1.
- R6: After expiry, `count` stays at 0 and `irq` stays at 1 through further ticks until `irq_ack`=1 clears `irq` at the next edge.
- R7: When an accepted load and a tick fall in the same cycle, the load wins: `count` takes `load_val` and is not decremented.
- R8: While the counter is stopped, ticks have no effect. It is stopped after reset, after expiry, and after a monitor-mode load of 0. A load of 0 does not raise `irq`.
- R9: When the expiring tick and `irq_ack` fall in the same cycle, `irq` is set. The expiry wins over the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_user | input | 1 | Current privilege: 1 = user mode, 0 = monitor mode |
| load_req | input | 1 | Request to load a new count |
| load_val | input | CNT_W | Count to load |
| tick_en | input | 1 | Tick enable; the counter steps only on cycles where this is high |
| irq_ack | input | 1 | Acknowledge; clears a pending interrupt |
| count | output | CNT_W | Current counter value |
| irq | output | 1 | Time-slice interrupt, held until acknowledged or reloaded |
| priv_viol | output | 1 | One-cycle flag for a load attempted in user mode |

## Verification
All three outputs are registered. The result of any stimulus is due exactly one rising edge after the cycle in which it is presented. This covers a new `count` value, the setting or clearing of `irq`, and the `priv_viol` pulse. The bench drives inputs on the falling edge and compares the outputs at the next falling edge, half a period after the edge that updates them. That way each check looks at the cycle in which its result is due. Multi-step cases, such as a run down to zero or a hold after expiry, are chained one vector per cycle, and every step is checked.

// File: rtl/slice_timer_pkg.sv
package slice_timer_pkg;
  typedef enum logic [1:0] {
    LD_NONE   = 2'b00,
    LD_ACCEPT = 2'b01,
    LD_REJECT = 2'b10
  } load_kind_e;
endpackage

// File: rtl/slice_mode_gate.sv
module slice_mode_gate
  import slice_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_user,
  input  logic       load_req,
  output load_kind_e load_kind,
  output logic       priv_viol
);
  logic viol_d, viol_q;

  always_comb begin
    if (!load_req)      load_kind = LD_NONE;
    else if (mode_user) load_kind = LD_REJECT;
    else                load_kind = LD_ACCEPT;
  end

  always_comb viol_d = (load_kind == LD_REJECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign priv_viol = viol_q;

  assert_viol_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && mode_user) |=> priv_viol);
  assert_viol_only_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_req && mode_user) |=> !priv_viol);
endmodule

// File: rtl/slice_down_counter.sv
module slice_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ok,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    expire = 1'b0;
    cnt_en = 1'b0;
    if (load_ok) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
      run_d  = (load_val != ZERO);
    end else if (run_q && tick_en) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
      if (cnt_q == ONE) begin
        run_d  = 1'b0;
        expire = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      run_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign count = cnt_q;

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ok && !tick_en) |=> $stable(count));
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ok && tick_en && run_q) |=> (count == $past(count) - ONE));
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (count == $past(load_val)));
  assert_stay_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ok && count == ZERO) |=> (count == ZERO));
endmodule

// File: rtl/slice_irq_latch.sv
module slice_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic load_ok,
  input  logic irq_ack,
  output logic irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (expire)                  irq_d = 1'b1;
    else if (load_ok || irq_ack) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);
  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !expire) |=> !irq);
  assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && !expire) |=> !irq);
  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack && !load_ok) |=> irq);
endmodule

// File: rtl/slice_timer.sv
module slice_timer
  import slice_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_user,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick_en,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             priv_viol
);
  load_kind_e kind;
  logic       load_ok;
  logic       expire;

  slice_mode_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_user (mode_user),
    .load_req  (load_req),
    .load_kind (kind),
    .priv_viol (priv_viol)
  );

  assign load_ok = (kind == LD_ACCEPT);

  slice_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ok  (load_ok),
    .load_val (load_val),
    .tick_en  (tick_en),
    .count    (count),
    .expire   (expire)
  );

  slice_irq_latch u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .load_ok (load_ok),
    .irq_ack (irq_ack),
    .irq     (irq)
  );

  assert_user_no_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && mode_user && !tick_en) |=> $stable(count));
  assert_mon_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !mode_user) |=> (count == $past(load_val)));
  assert_zero_load_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !mode_user && load_val == '0) |=> !irq);
endmodule

// File: tb/slice_timer_tb_top.sv
module slice_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_user = 1'b0, load_req = 1'b0, tick_en = 1'b0, irq_ack = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count;
  logic         irq, priv_viol;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_user(mode_user), .load_req(load_req),
    .load_val(load_val), .tick_en(tick_en), .irq_ack(irq_ack),
    .count(count), .irq(irq), .priv_viol(priv_viol)
  );

  // vector: {user, load, val[8], tick, ack, exp_cnt[8], exp_irq, exp_viol, tag[4]}
  typedef logic [25:0] vec_t;
  function automatic vec_t mk(bit u, bit l, int v, bit t, bit a, int ec, bit ei, bit ev, int tag);
    return {u, l, 8'(v), t, a, 8'(ec), ei, ev, 4'(tag)};
  endfunction

  localparam vec_t VEC [NV] = '{
    mk(1,1,5,0,0, 0,0,1, 3),   // R3 user load rejected, counter stays 0
    mk(0,0,0,1,0, 0,0,0, 8),   // R8 stopped after reset: tick ignored
    mk(0,1,3,1,0, 3,0,0, 7),   // R7 load beats tick
    mk(0,0,0,1,0, 2,0,0, 4),   // R4 decrement
    mk(0,0,0,0,0, 2,0,0, 4),   // R4 hold without tick
    mk(1,1,9,1,0, 1,0,1, 3),   // R3 user load ignored, tick still counts
    mk(0,0,0,1,0, 0,1,0, 5),   // R5 expiry sets irq
    mk(0,0,0,1,0, 0,1,0, 6),   // R6 holds at zero with irq
    mk(1,1,7,1,0, 0,1,1, 3),   // R3 user load cannot clear irq
    mk(0,0,0,0,1, 0,0,0, 6),   // R6 ack clears irq
    mk(0,0,0,1,0, 0,0,0, 8),   // R8 stopped after expiry
    mk(0,1,2,0,0, 2,0,0, 2),   // R2 monitor load
    mk(0,0,0,1,0, 1,0,0, 4),   // R4 decrement
    mk(0,0,0,1,1, 0,1,0, 9),   // R9 expiry beats ack
    mk(0,1,4,0,0, 4,0,0, 2),   // R2 load clears irq
    mk(0,1,0,1,0, 0,0,0, 8),   // R8 load of zero stops, no irq
    mk(0,0,0,1,0, 0,0,0, 8),   // R8 still stopped
    mk(0,0,0,1,0, 0,0,0, 8)    // R8 still stopped, irq stays low
  };

  task automatic check(string req, logic [W-1:0] ec, logic ei, logic ev);
    n_chk++;
    if (count !== ec || irq !== ei || priv_viol !== ev) begin
      n_bad++;
      $display("FAIL %s: count=%0d irq=%0b viol=%0b expected count=%0d irq=%0b viol=%0b",
               req, count, irq, priv_viol, ec, ei, ev);
    end
  endtask

  task automatic drive(bit u, bit l, logic [W-1:0] v, bit t, bit a);
    mode_user = u; load_req = l; load_val = v; tick_en = t; irq_ack = a;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0, 0, 0);                 // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      drive(v[25], v[24], v[23:16], v[15], v[14]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", v[3:0], i), v[13:6], v[5], v[4]);
    end

    // R4 boundary: full-scale load then one tick
    drive(0,1,8'hFF,0,0); @(negedge clk); check("R2", 8'hFF, 0, 0);
    drive(0,0,0,1,0);     @(negedge clk); check("R4", 8'hFE, 0, 0);
    // R3 user load without tick: count unchanged, viol one cycle only
    drive(1,1,8'h10,0,0); @(negedge clk); check("R3", 8'hFE, 0, 1);
    drive(0,0,0,0,0);     @(negedge clk); check("R3", 8'hFE, 0, 0);
    // R5 load of one expires on the next tick
    drive(0,1,1,0,0);     @(negedge clk); check("R5", 1, 0, 0);
    drive(0,0,0,1,0);     @(negedge clk); check("R5", 0, 1, 0);
    // R1 asynchronous reset mid-run
    drive(0,1,8'h20,0,0); @(negedge clk);
    rst_n = 1'b0; drive(0,0,0,0,0);
    #1; check("R1", 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    drive(0,0,0,1,0);     @(negedge clk); check("R1", 0, 0, 0);  // stopped after reset

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule